// File: doc/BRIEF.md
# Software Flow-Control Character Inserter for a UART Transmitter

This block sits between a transmit FIFO and a UART serializer. It decides when the transmitter has to send software flow-control characters. It compares the local receive FIFO fill level with two programmable thresholds. When the FIFO fills past the stop threshold, the block inserts a stop ("Xoff") character or character pair. When the FIFO drains to the restart threshold, it inserts a restart ("Xon") character or pair. Flow-control characters have priority over queued data bytes. They use the same valid/ready handshake as data, so the serializer cannot tell the two apart.

The block remembers that the link is halted. When the Xoff goes out, it captures the mode and the restart characters in effect at that moment. If software then changes the flow-control mode while the remote side is halted, the block first sends the restart characters that were captured. After that, if the receive FIFO is still too full, it sends the stop characters of the new mode. Disabling transmit flow control while halted therefore always releases the remote side. Writes to the character registers after a halt cannot corrupt the recovery character. Each flow-control character is trimmed to the configured word length at the moment it is scheduled.

Top module: `xonxoff_tx_ctrl`

## Requirements
- R1: The stop level is `thresholds[3:0]*4` and the restart level is `thresholds[7:4]*4`. A stop is due only when `rx_level` is strictly greater than the stop level. A restart is due when `rx_level` is less than or equal to the restart level.
- R2: When the link is not halted, transmit flow control is enabled and `rx_level` exceeds the stop level, the block emits the stop character(s) of the current mode. It is halted once the last of them has been accepted.
- R3: When the link is halted, the mode is unchanged and `rx_level` is at or below the restart level, the block emits the restart character(s). It leaves the halted state once the last of them has been accepted.
- R4: `fc_mode[3:2]` selects the characters. 00 means no transmit flow control. 10 uses character set 1 (`xon1_chr`/`xoff1_chr`). 01 uses set 2. 11 sends the set-1 character followed by the set-2 character.
- R5: Setting `fc_mode[3:2]` to 00 while halted makes the block emit the captured restart character(s). No further flow characters follow while the mode stays 00.
- R6: Any change of the 4-bit `fc_mode` while halted makes the block emit the restart character(s) of the captured mode. Then, if `rx_level` still exceeds the stop level, it emits the stop character(s) of the new mode.
- R7: The restart characters and mode are captured when a stop sequence is scheduled. Later writes to `xon1_chr`/`xon2_chr` alter neither the recovery character nor the halted state, and on their own emit nothing.
- R8: `word_len` encodes 00=5, 01=6, 10=7, 11=8 bits. A flow character is sent with the bits above that width cleared, using the `word_len` value at the time the character is scheduled.
- R9: When the output is not holding an unaccepted byte and a flow character is pending, the flow character is presented, and `in_ready` stays low.
- R10: A byte presented on `out_valid` that is not yet accepted stays valid with unchanged `out_data` until `out_ready`; a flow character never pre-empts it.
- R11: During and right after reset the block is not halted, has nothing pending and drives `out_valid` low unless a data byte is offered.
- R12: With no flow character pending, data passes straight through: `out_valid=in_valid`, `out_data=in_data`, `in_ready=out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 7 | Receive FIFO fill level in entries |
| thresholds | input | 8 | Restart nibble [7:4], stop nibble [3:0], each in units of 4 entries |
| fc_mode | input | 4 | Flow-control mode; [3:2] selects transmit characters |
| xon1_chr | input | 8 | Restart character, set 1 |
| xon2_chr | input | 8 | Restart character, set 2 |
| xoff1_chr | input | 8 | Stop character, set 1 |
| xoff2_chr | input | 8 | Stop character, set 2 |
| word_len | input | 2 | Character width code (5 to 8 bits) |
| in_valid | input | 1 | Data byte available from the transmit FIFO |
| in_data | input | 8 | Data byte from the transmit FIFO |
| in_ready | output | 1 | Data byte taken this cycle |
| out_valid | output | 1 | Byte offered to the serializer |
| out_data | output | 8 | Byte offered to the serializer |
| out_ready | input | 1 | Serializer accepts the offered byte |

## Verification
Most wrong internal states in this block show up at the ports. A lost or spurious halted flag turns up as a missing or extra restart character at the next threshold crossing or mode write. A corrupted captured restart character appears as a wrong byte on `out_data`, within a few cycles of the mode change that triggers recovery. A faulty hold lock shows up in the first cycle after a stalled handshake, as a changed `out_data` or a dropped `out_valid`. Comparing the output cycle by cycle against a behavioural model catches a wrong arbitration decision in the very cycle it happens.

// File: rtl/xf_pkg.sv
package xf_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_FIRST  = 2'd1,
      SEQ_SECOND = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      TXM_OFF  = 2'b00,
      TXM_SET2 = 2'b01,
      TXM_SET1 = 2'b10,
      TXM_BOTH = 2'b11
   } txm_e;

   typedef enum logic {
      SRC_DATA = 1'b0,
      SRC_FLOW = 1'b1
   } src_e;

   localparam int MIN_WORD_BITS = 5;

endpackage

// File: rtl/xf_thresh_cmp.sv
module xf_thresh_cmp #(
   parameter int LVL_W       = 7,
   parameter int NIB_W       = 4,
   parameter int SHIFT       = 2,
   parameter bit HALT_STRICT = 1'b1
) (
   input  logic [LVL_W-1:0]   level,
   input  logic [2*NIB_W-1:0] thr,
   output logic               above_halt,
   output logic               at_resume
);
   localparam int SCALED_W = NIB_W + SHIFT;
   localparam int CMP_W    = (SCALED_W > LVL_W) ? SCALED_W : LVL_W;

   logic [CMP_W-1:0] halt_lvl;
   logic [CMP_W-1:0] resume_lvl;
   logic [CMP_W-1:0] lvl_ext;

   generate
      if (NIB_W < 1) begin : g_bad_nib
         $error("xf_thresh_cmp: NIB_W must be at least 1");
      end
   endgenerate

   assign halt_lvl   = CMP_W'(thr[NIB_W-1:0]) << SHIFT;
   assign resume_lvl = CMP_W'(thr[2*NIB_W-1:NIB_W]) << SHIFT;
   assign lvl_ext    = CMP_W'(level);

   generate
      if (HALT_STRICT) begin : g_strict
         assign above_halt = lvl_ext > halt_lvl;
      end else begin : g_incl
         assign above_halt = lvl_ext >= halt_lvl;
      end
   endgenerate

   assign at_resume = lvl_ext <= resume_lvl;

endmodule

// File: rtl/xf_char_pick.sv
module xf_char_pick
   import xf_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic [1:0]        txm,
   input  logic [CHAR_W-1:0] c1,
   input  logic [CHAR_W-1:0] c2,
   input  logic [1:0]        wlen,
   output logic              two,
   output logic [CHAR_W-1:0] first,
   output logic [CHAR_W-1:0] second
);
   logic [CHAR_W-1:0] mask;
   logic [CHAR_W-1:0] raw_a;
   logic [CHAR_W-1:0] raw_b;

   generate
      for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
         if (i < MIN_WORD_BITS) begin : g_always
            assign mask[i] = 1'b1;
         end else if (i < 8) begin : g_coded
            assign mask[i] = (wlen >= 2'(i - 4));
         end else begin : g_wide
            assign mask[i] = (wlen == 2'd3);
         end
      end
   endgenerate

   always_comb begin
      two   = 1'b0;
      raw_a = c1;
      raw_b = c1;
      case (txm)
         TXM_SET2: begin
            raw_a = c2;
            raw_b = c2;
         end
         TXM_BOTH: begin
            two   = 1'b1;
            raw_a = c1;
            raw_b = c2;
         end
         default: begin
            raw_a = c1;
            raw_b = c1;
         end
      endcase
   end

   assign first  = raw_a & mask;
   assign second = raw_b & mask;

endmodule

// File: rtl/xf_seq.sv
module xf_seq
   import xf_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        mode,
   input  logic              above_halt,
   input  logic              at_resume,
   input  logic [CHAR_W-1:0] xon1,
   input  logic [CHAR_W-1:0] xon2,
   input  logic [CHAR_W-1:0] xoff1,
   input  logic [CHAR_W-1:0] xoff2,
   input  logic [1:0]        wlen,
   input  logic              flow_ack,
   output logic              flow_req,
   output logic [CHAR_W-1:0] flow_char,
   output logic              halted
);
   seq_state_e        state;
   logic [3:0]        saved_mode;
   logic [CHAR_W-1:0] saved_on1;
   logic [CHAR_W-1:0] saved_on2;
   logic [CHAR_W-1:0] ch_a;
   logic [CHAR_W-1:0] ch_b;
   logic              two;
   logic              kind_xoff;

   logic              off_two;
   logic              on_two;
   logic [CHAR_W-1:0] off_a;
   logic [CHAR_W-1:0] off_b;
   logic [CHAR_W-1:0] on_a;
   logic [CHAR_W-1:0] on_b;
   logic              mode_moved;
   logic              want_on;
   logic              want_off;

   xf_char_pick #(.CHAR_W(CHAR_W)) u_off_pick (
      .txm    (mode[3:2]),
      .c1     (xoff1),
      .c2     (xoff2),
      .wlen   (wlen),
      .two    (off_two),
      .first  (off_a),
      .second (off_b)
   );

   xf_char_pick #(.CHAR_W(CHAR_W)) u_on_pick (
      .txm    (saved_mode[3:2]),
      .c1     (saved_on1),
      .c2     (saved_on2),
      .wlen   (wlen),
      .two    (on_two),
      .first  (on_a),
      .second (on_b)
   );

   assign mode_moved = halted && (mode != saved_mode);
   assign want_on    = halted && (mode_moved || at_resume);
   assign want_off   = !halted && (mode[3:2] != TXM_OFF) && above_halt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         halted     <= 1'b0;
         saved_mode <= '0;
         saved_on1  <= '0;
         saved_on2  <= '0;
         ch_a       <= '0;
         ch_b       <= '0;
         two        <= 1'b0;
         kind_xoff  <= 1'b0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (want_on) begin
                  ch_a      <= on_a;
                  ch_b      <= on_b;
                  two       <= on_two;
                  kind_xoff <= 1'b0;
                  state     <= SEQ_FIRST;
               end else if (want_off) begin
                  ch_a       <= off_a;
                  ch_b       <= off_b;
                  two        <= off_two;
                  kind_xoff  <= 1'b1;
                  saved_mode <= mode;
                  saved_on1  <= xon1;
                  saved_on2  <= xon2;
                  state      <= SEQ_FIRST;
               end
            end
            SEQ_FIRST: begin
               if (flow_ack) begin
                  if (two) begin
                     state <= SEQ_SECOND;
                  end else begin
                     state  <= SEQ_IDLE;
                     halted <= kind_xoff;
                  end
               end
            end
            SEQ_SECOND: begin
               if (flow_ack) begin
                  state  <= SEQ_IDLE;
                  halted <= kind_xoff;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign flow_req  = (state != SEQ_IDLE);
   assign flow_char = (state == SEQ_SECOND) ? ch_b : ch_a;

endmodule

// File: rtl/xf_arb.sv
module xf_arb
   import xf_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_req,
   input  logic [CHAR_W-1:0] flow_char,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_data,
   output logic              flow_ack,
   output logic              locked
);
   src_e held_src;
   src_e src;

   always_comb begin
      if (locked) begin
         src = held_src;
      end else if (flow_req) begin
         src = SRC_FLOW;
      end else begin
         src = SRC_DATA;
      end
   end

   always_comb begin
      if (src == SRC_FLOW) begin
         out_valid = flow_req;
         out_data  = flow_char;
         in_ready  = 1'b0;
         flow_ack  = flow_req && out_ready;
      end else begin
         out_valid = in_valid;
         out_data  = in_data;
         in_ready  = out_ready;
         flow_ack  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         held_src <= SRC_DATA;
      end else begin
         locked   <= out_valid && !out_ready;
         held_src <= src;
      end
   end

endmodule

// File: rtl/xonxoff_tx_ctrl.sv
module xonxoff_tx_ctrl #(
   parameter int LVL_W       = 7,
   parameter int CHAR_W      = 8,
   parameter int NIB_W       = 4,
   parameter int THR_SHIFT   = 2,
   parameter bit HALT_STRICT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LVL_W-1:0]   rx_level,
   input  logic [2*NIB_W-1:0] thresholds,
   input  logic [3:0]         fc_mode,
   input  logic [CHAR_W-1:0]  xon1_chr,
   input  logic [CHAR_W-1:0]  xon2_chr,
   input  logic [CHAR_W-1:0]  xoff1_chr,
   input  logic [CHAR_W-1:0]  xoff2_chr,
   input  logic [1:0]         word_len,
   input  logic               in_valid,
   input  logic [CHAR_W-1:0]  in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [CHAR_W-1:0]  out_data,
   input  logic               out_ready
);
   localparam int MAX_THR_LVL = ((1 << NIB_W) - 1) << THR_SHIFT;

   generate
      if (CHAR_W < 8) begin : g_bad_char
         $error("xonxoff_tx_ctrl: CHAR_W must be at least 8");
      end
      if (MAX_THR_LVL >= (1 << LVL_W)) begin : g_bad_lvl
         $error("xonxoff_tx_ctrl: LVL_W too narrow for the threshold range");
      end
   endgenerate

   logic              above_halt;
   logic              at_resume;
   logic              flow_req;
   logic [CHAR_W-1:0] flow_char;
   logic              flow_ack;
   logic              halted;
   logic              arb_locked;

   xf_thresh_cmp #(
      .LVL_W       (LVL_W),
      .NIB_W       (NIB_W),
      .SHIFT       (THR_SHIFT),
      .HALT_STRICT (HALT_STRICT)
   ) u_cmp (
      .level      (rx_level),
      .thr        (thresholds),
      .above_halt (above_halt),
      .at_resume  (at_resume)
   );

   xf_seq #(.CHAR_W(CHAR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (fc_mode),
      .above_halt (above_halt),
      .at_resume  (at_resume),
      .xon1       (xon1_chr),
      .xon2       (xon2_chr),
      .xoff1      (xoff1_chr),
      .xoff2      (xoff2_chr),
      .wlen       (word_len),
      .flow_ack   (flow_ack),
      .flow_req   (flow_req),
      .flow_char  (flow_char),
      .halted     (halted)
   );

   xf_arb #(.CHAR_W(CHAR_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flow_req  (flow_req),
      .flow_char (flow_char),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .flow_ack  (flow_ack),
      .locked    (arb_locked)
   );

endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [CHAR_W-1:0] out_data,
   input logic              in_ready,
   input logic              flow_req,
   input logic              arb_locked,
   input logic              halted,
   input logic              flow_ack
);

   assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_data_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_ready);

   assert_flow_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_req && !arb_locked) |-> !in_ready);

   assert_halt_on_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(flow_ack));

   assert_resume_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted) |-> $past(flow_ack));

endmodule

bind xonxoff_tx_ctrl xf_checker #(.CHAR_W(CHAR_W)) u_xf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .in_ready   (in_ready),
   .flow_req   (flow_req),
   .arb_locked (arb_locked),
   .halted     (halted),
   .flow_ack   (flow_ack)
);

// File: tb/xonxoff_tx_ctrl_test.sv
module xonxoff_tx_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk;
   logic       rst_n;
   logic [6:0] rx_level;
   logic [7:0] thresholds;
   logic [3:0] fc_mode;
   logic [7:0] xon1_chr, xon2_chr, xoff1_chr, xoff2_chr;
   logic [1:0] word_len;
   logic       in_valid;
   logic [7:0] in_data;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_ready;

   xonxoff_tx_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thresholds(thresholds),
      .fc_mode(fc_mode), .xon1_chr(xon1_chr), .xon2_chr(xon2_chr),
      .xoff1_chr(xoff1_chr), .xoff2_chr(xoff2_chr), .word_len(word_len),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int         d_total = 0, d_bad = 0;
   int         m_total = 0, m_bad = 0;
   int         sent_rd = 0;
   string      cur_req = "R11";
   logic [7:0] sent[$];

   // behavioural reference state
   logic [7:0] mq[$];
   bit         m_halted, m_kxoff, m_lock, m_hsel;
   logic [3:0] m_smode;
   logic [7:0] m_s1, m_s2;

   function automatic logic [7:0] wmask(logic [1:0] w);
      case (w)
         2'd0:    return 8'h1F;
         2'd1:    return 8'h3F;
         2'd2:    return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic void mpush(logic [1:0] t, logic [7:0] a, logic [7:0] b, logic [1:0] w);
      if (t == 2'b10) mq.push_back(a & wmask(w));
      else if (t == 2'b01) mq.push_back(b & wmask(w));
      else if (t == 2'b11) begin
         mq.push_back(a & wmask(w));
         mq.push_back(b & wmask(w));
      end
   endfunction

   always @(negedge clk) begin
      bit         freq, sel, ev, ack, idle;
      logic [7:0] fch, ed;
      int         hl, rl;
      if (!rst_n) begin
         mq.delete();
         m_halted = 0; m_kxoff = 0; m_lock = 0; m_hsel = 0;
         m_smode = '0; m_s1 = '0; m_s2 = '0;
      end else begin
         freq = (mq.size() != 0);
         fch  = freq ? mq[0] : 8'h00;
         sel  = m_lock ? m_hsel : freq;
         ev   = sel ? freq : in_valid;
         ed   = sel ? fch : in_data;
         m_total++;
         if (out_valid !== ev) begin
            m_bad++;
            $display("FAIL %s out_valid got %0b expected %0b at %0t", cur_req, out_valid, ev, $time);
         end
         if (ev) begin
            m_total++;
            if (out_data !== ed) begin
               m_bad++;
               $display("FAIL %s out_data got %02h expected %02h at %0t", cur_req, out_data, ed, $time);
            end
         end
         m_total++;
         if (in_ready !== (!sel && out_ready)) begin
            m_bad++;
            $display("FAIL %s in_ready got %0b expected %0b at %0t", cur_req, in_ready, (!sel && out_ready), $time);
         end
         if (out_valid && out_ready) sent.push_back(out_data);
         ack    = sel && freq && out_ready;
         idle   = !freq;
         m_lock = ev && !out_ready;
         m_hsel = sel;
         if (idle) begin
            hl = int'(thresholds[3:0]) * 4;
            rl = int'(thresholds[7:4]) * 4;
            if (m_halted && (fc_mode != m_smode || int'(rx_level) <= rl)) begin
               mpush(m_smode[3:2], m_s1, m_s2, word_len);
               m_kxoff = 0;
            end else if (!m_halted && fc_mode[3:2] != 2'b00 && int'(rx_level) > hl) begin
               mpush(fc_mode[3:2], xoff1_chr, xoff2_chr, word_len);
               m_kxoff = 1;
               m_smode = fc_mode; m_s1 = xon1_chr; m_s2 = xon2_chr;
            end
         end else if (ack) begin
            void'(mq.pop_front());
            if (mq.size() == 0) m_halted = m_kxoff;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      d_total++;
      if (!ok) begin
         d_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
      step(2);
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
      step(1);
      rst_n = 1'b1;
      step(1);
      sent_rd = sent.size();
   endtask

   task automatic expect_sent(string req, int n, logic [7:0] a, logic [7:0] b);
      int got;
      got = sent.size() - sent_rd;
      chk(got == n, req, "flow char count", got, n);
      if (n >= 1 && got >= 1) chk(sent[sent_rd] == a, req, "first char", int'(sent[sent_rd]), int'(a));
      if (n >= 2 && got >= 2) chk(sent[sent_rd+1] == b, req, "second char", int'(sent[sent_rd+1]), int'(b));
      sent_rd = sent.size();
   endtask

   task automatic run_toggle(int n);
      for (int k = 0; k < n; k++) begin
         out_ready = ((k % 3) != 1);
         step(1);
      end
      out_ready = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", d_total + m_total + 1, d_bad + m_bad + 1);
      $finish;
   end

   initial begin
      int n_off, n_on;
      rx_level = '0; thresholds = 8'h12; fc_mode = 4'b1000;
      xon1_chr = 8'hE1; xon2_chr = 8'hE2; xoff1_chr = 8'hD3; xoff2_chr = 8'hD4;
      word_len = 2'd3; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
      do_reset();
      chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
      step(4);
      expect_sent("R11", 0, 8'h00, 8'h00);

      // thresholds: stop level 8, restart level 4
      cur_req = "R1"; rx_level = 7'd8; step(6); expect_sent("R1", 0, 0, 0);
      cur_req = "R2"; rx_level = 7'd9; step(6); expect_sent("R2", 1, 8'hD3, 0);
      cur_req = "R1"; rx_level = 7'd5; step(6); expect_sent("R1", 0, 0, 0);
      cur_req = "R3"; rx_level = 7'd4; step(6); expect_sent("R3", 1, 8'hE1, 0);

      cur_req = "R4"; do_reset(); fc_mode = 4'b1100;
      rx_level = 7'd9; step(8); expect_sent("R4", 2, 8'hD3, 8'hD4);
      rx_level = 7'd0; step(8); expect_sent("R4", 2, 8'hE1, 8'hE2);
      do_reset(); fc_mode = 4'b0100;
      rx_level = 7'd20; step(6); expect_sent("R4", 1, 8'hD4, 0);
      rx_level = 7'd0; step(6); expect_sent("R4", 1, 8'hE2, 0);
      do_reset(); fc_mode = 4'b0000;
      rx_level = 7'd60; step(6); expect_sent("R4", 0, 0, 0);

      cur_req = "R8"; do_reset(); fc_mode = 4'b1000; word_len = 2'd0;
      rx_level = 7'd9; step(6); expect_sent("R8", 1, 8'h13, 0);
      word_len = 2'd1; rx_level = 7'd0; step(6); expect_sent("R8", 1, 8'h21, 0);
      do_reset(); word_len = 2'd2;
      rx_level = 7'd9; step(6); expect_sent("R8", 1, 8'h53, 0);
      word_len = 2'd3;

      cur_req = "R5"; do_reset(); fc_mode = 4'b1000;
      rx_level = 7'd9; step(6); expect_sent("R5", 1, 8'hD3, 0);
      fc_mode = 4'b0000; step(6); expect_sent("R5", 1, 8'hE1, 0);
      step(6); expect_sent("R5", 0, 0, 0);

      cur_req = "R7"; do_reset(); fc_mode = 4'b1000;
      rx_level = 7'd9; step(6); expect_sent("R7", 1, 8'hD3, 0);
      xon1_chr = 8'h55; step(6); expect_sent("R7", 0, 0, 0);
      cur_req = "R6"; fc_mode = 4'b0100; step(10);
      expect_sent("R6", 2, 8'hE1, 8'hD4);
      xon1_chr = 8'hE1;

      cur_req = "R12"; do_reset(); fc_mode = 4'b0000;
      in_valid = 1'b1; in_data = 8'h5A;
      run_toggle(20);
      cur_req = "R9"; fc_mode = 4'b1000; rx_level = 7'd9;
      run_toggle(30);
      cur_req = "R10"; rx_level = 7'd0;
      run_toggle(30);
      n_off = 0; n_on = 0;
      for (int i = sent_rd; i < sent.size(); i++) begin
         if (sent[i] == 8'hD3) n_off++;
         if (sent[i] == 8'hE1) n_on++;
      end
      chk(n_off == 1, "R9", "stop chars amid data", n_off, 1);
      chk(n_on == 1, "R10", "restart chars amid data", n_on, 1);
      in_valid = 1'b0;
      step(4);

      $display("test done: total=%0d bad=%0d", d_total + m_total, d_bad + m_bad);
      $finish;
   end

endmodule